// File: doc/BRIEF.md
# Nested Sixteen-Channel Interrupt Controller

This block collects single-cycle event pulses from sixteen peripheral sources and turns them into one active-low interrupt request. Each channel has four state bits: enable, mask, pending and in-service. The bits are grouped into an upper bank (channels 15..8) and a lower bank (channels 7..0), and each bank is reached as one 8-bit register on a simple synchronous register bus. An event on an enabled channel latches its pending bit. A pending bit that is not masked competes for service under a fixed priority in which the channel index is the priority.

When the processor strobes `ack`, the controller accepts the winning channel. It clears that channel's pending bit and, one cycle later, reports the channel index on `ack_id` with `ack_vld`. In software end-of-interrupt mode the accepted channel's in-service bit also sets. That bit then blocks requests of equal or lower priority until software clears it. Requests of higher priority can still interrupt, which gives nested service. In automatic mode no in-service bit is set.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1. The register map is: 0x7 upper enable, 0x8 lower enable, 0x9 upper pending, 0xA lower pending, 0xB upper in-service, 0xC lower in-service, 0xD upper mask, 0xE lower mask, 0xF control (bit 0 = 1 selects software end-of-interrupt mode). Register bit k of an upper register is channel 8+k. Register bit k of a lower register is channel k.
- R2: The enable registers hold the last value written and can be read at any time. A write to a register takes effect at the next clock edge. Reads are combinational from `addr`.
- R3: An event pulse (`evt` bit = channel) on a disabled channel leaves its pending bit at 0 and does not request an interrupt.
- R4: An event pulse on an enabled channel sets its pending bit. If the channel is unmasked and no in-service bit is set, `irq_n` drops to 0.
- R5: Writing 0 to an enable bit clears that channel's pending bit in the same write. `irq_n` returns to 1 unless another channel still requests service.
- R6: A mask bit of 1 keeps the channel's pending bit set but stops it from driving `irq_n`.
- R7: The winner is the highest-index channel that is pending and unmasked. An `ack` while `irq_n` is 0 clears the winner's pending bit and, on the next cycle, pulses `ack_vld` for one cycle with the winner's index on `ack_id`.
- R8: In software end-of-interrupt mode an accepted channel's in-service bit sets. `irq_n` is 0 only when the winner's index is above every in-service channel's index.
- R9: Writing to an enable register never changes any in-service bit.
- R10: Writing 0 to a pending or in-service bit clears it. Writing 1 leaves it unchanged.
- R11: If an event pulse and a write of 0 hit the same pending bit in the same cycle, the bit ends up set.
- R12: In automatic mode (control bit 0 = 0) an acknowledge leaves all in-service bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| evt | input | 16 | Event pulses, one per channel |
| ack | input | 1 | Acknowledge strobe |
| irq_n | output | 1 | Active-low interrupt request |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_id | output | 4 | Accepted channel index |

## Verification
The bench disables a channel that is pending while a second channel is also pending. A design that drops the request outright, or that leaves the stale pending bit set, shows the wrong `irq_n` or the wrong pending readback. It nests a higher-priority acceptance over a lower in-service channel and then confirms that a lower request stays blocked until the in-service bit is cleared. A design that compares priority in the wrong direction, or ignores in-service state, raises `irq_n` too early or too late. It also writes 1s to pending and in-service bits, disables a channel that is in service, and collides an event with a clearing write. A design that treats the write as a store, or lets the clear win, reads back a value that differs from the expected one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IRQC_EN_HI   = 7;
    localparam int IRQC_EN_LO   = 8;
    localparam int IRQC_PND_HI  = 9;
    localparam int IRQC_PND_LO  = 10;
    localparam int IRQC_ISV_HI  = 11;
    localparam int IRQC_ISV_LO  = 12;
    localparam int IRQC_MSK_HI  = 13;
    localparam int IRQC_MSK_LO  = 14;
    localparam int IRQC_CTRL    = 15;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N   = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Highest set bit wins: later iterations overwrite earlier ones.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
    import irqc_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 4,
    localparam int CH    = 2 * BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CH-1:0]     en,
    input  logic [CH-1:0]     mask,
    input  logic [CH-1:0]     pend,
    input  logic [CH-1:0]     isv,
    input  logic              soft_eoi,
    output logic [BANK_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(IRQC_EN_HI):  rdata = en[CH-1:BANK_W];
            ADDR_W'(IRQC_EN_LO):  rdata = en[BANK_W-1:0];
            ADDR_W'(IRQC_PND_HI): rdata = pend[CH-1:BANK_W];
            ADDR_W'(IRQC_PND_LO): rdata = pend[BANK_W-1:0];
            ADDR_W'(IRQC_ISV_HI): rdata = isv[CH-1:BANK_W];
            ADDR_W'(IRQC_ISV_LO): rdata = isv[BANK_W-1:0];
            ADDR_W'(IRQC_MSK_HI): rdata = mask[CH-1:BANK_W];
            ADDR_W'(IRQC_MSK_LO): rdata = mask[BANK_W-1:0];
            ADDR_W'(IRQC_CTRL):   rdata = BANK_W'(soft_eoi);
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 4,
    localparam int CH    = 2 * BANK_W,
    localparam int ID_W  = $clog2(CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata,
    input  logic [CH-1:0]     evt,
    input  logic              ack,
    output logic              irq_n,
    output logic              ack_vld,
    output logic [ID_W-1:0]   ack_id
);
    typedef struct packed {
        logic [CH-1:0]   en;
        logic [CH-1:0]   mask;
        logic [CH-1:0]   pend;
        logic [CH-1:0]   isv;
        logic            soft_eoi;
        logic            ack_vld;
        logic [ID_W-1:0] ack_id;
    } state_t;

    state_t st_d, st_q;

    logic [CH-1:0]   en_q, mask_q, pend_q, isv_q;
    logic            soft_eoi_q;
    logic            req_any, isv_any, grant;
    logic [ID_W-1:0] req_idx, isv_idx;

    assign en_q       = st_q.en;
    assign mask_q     = st_q.mask;
    assign pend_q     = st_q.pend;
    assign isv_q      = st_q.isv;
    assign soft_eoi_q = st_q.soft_eoi;

    irqc_prio_enc #(.N(CH)) u_req_enc (
        .vec   (st_q.pend & ~st_q.mask),
        .found (req_any),
        .idx   (req_idx)
    );

    irqc_prio_enc #(.N(CH)) u_isv_enc (
        .vec   (st_q.isv),
        .found (isv_any),
        .idx   (isv_idx)
    );

    assign grant = req_any && (!isv_any || (req_idx > isv_idx));

    always_comb begin
        st_d         = st_q;
        st_d.ack_vld = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_W'(IRQC_EN_HI):  st_d.en[CH-1:BANK_W]     = wdata;
                ADDR_W'(IRQC_EN_LO):  st_d.en[BANK_W-1:0]      = wdata;
                ADDR_W'(IRQC_MSK_HI): st_d.mask[CH-1:BANK_W]   = wdata;
                ADDR_W'(IRQC_MSK_LO): st_d.mask[BANK_W-1:0]    = wdata;
                ADDR_W'(IRQC_PND_HI): st_d.pend[CH-1:BANK_W]   = st_q.pend[CH-1:BANK_W] & wdata;
                ADDR_W'(IRQC_PND_LO): st_d.pend[BANK_W-1:0]    = st_q.pend[BANK_W-1:0] & wdata;
                ADDR_W'(IRQC_ISV_HI): st_d.isv[CH-1:BANK_W]    = st_q.isv[CH-1:BANK_W] & wdata;
                ADDR_W'(IRQC_ISV_LO): st_d.isv[BANK_W-1:0]     = st_q.isv[BANK_W-1:0] & wdata;
                ADDR_W'(IRQC_CTRL):   st_d.soft_eoi            = wdata[0];
                default: ;
            endcase
        end
        if (ack && grant) begin
            st_d.pend[req_idx] = 1'b0;
            if (st_q.soft_eoi) begin
                st_d.isv[req_idx] = 1'b1;
            end
            st_d.ack_vld = 1'b1;
            st_d.ack_id  = req_idx;
        end
        // Disabled channels lose pending state; new events on enabled ones win.
        st_d.pend = (st_d.pend & st_d.en) | (evt & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irqc_rd_mux #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_rd_mux (
        .addr     (addr),
        .en       (st_q.en),
        .mask     (st_q.mask),
        .pend     (st_q.pend),
        .isv      (st_q.isv),
        .soft_eoi (st_q.soft_eoi),
        .rdata    (rdata)
    );

    assign irq_n   = ~grant;
    assign ack_vld = st_q.ack_vld;
    assign ack_id  = st_q.ack_id;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int CH     = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              ack,
    input logic              irq_n,
    input logic              ack_vld,
    input logic [CH-1:0]     en_q,
    input logic [CH-1:0]     mask_q,
    input logic [CH-1:0]     pend_q,
    input logic [CH-1:0]     isv_q,
    input logic              soft_eoi_q
);
    // R3
    pend_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~en_q) == '0);

    // R6
    irq_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((pend_q & ~mask_q) != '0));

    // R9
    disable_keeps_isv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ack && (addr == ADDR_W'(IRQC_EN_HI) || addr == ADDR_W'(IRQC_EN_LO)))
        |=> isv_q == $past(isv_q));

    // R7
    ack_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_n) |=> ack_vld);

    // R12
    auto_mode_isv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_en && !soft_eoi_q) |=> isv_q == $past(isv_q));
endmodule

bind irqc_top irqc_chk #(.CH(2 * BANK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .ack        (ack),
    .irq_n      (irq_n),
    .ack_vld    (ack_vld),
    .en_q       (en_q),
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .isv_q      (isv_q),
    .soft_eoi_q (soft_eoi_q)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] evt = '0;
    logic        ack = 1'b0;
    logic        irq_n, ack_vld;
    logic [3:0]  ack_id;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .evt(evt), .ack(ack), .irq_n(irq_n),
        .ack_vld(ack_vld), .ack_id(ack_id)
    );

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_evt(input logic [3:0] a, input logic [7:0] d, input logic [15:0] e);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; evt = e;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_chk(string tag, input logic [3:0] a, input int exp);
        addr = a;
        #2;
        check(tag, int'(rdata), exp);
    endtask

    task automatic do_ack(input int exp_id);
        @(negedge clk);
        exp_q.push_back(exp_id);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Monitor: compare each acknowledge result with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && ack_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7: got ack_id 0x%0h expected no acknowledge", ack_id);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(ack_id) != e) begin
                    n_bad++;
                    $display("FAIL R7: got ack_id 0x%0h expected 0x%0h", ack_id, e);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 7; a < 16; a++) rd_chk("R1 reg", 4'(a), 0);
        check("R1 irq_n", int'(irq_n), 1);

        // R3 events on disabled channels
        pulse(16'hFFFF);
        rd_chk("R3 pend hi", 4'd9, 0);
        rd_chk("R3 pend lo", 4'd10, 0);
        check("R3 irq_n", int'(irq_n), 1);

        // R2 enable readback
        wr(4'd8, 8'h3C);
        rd_chk("R2 en lo", 4'd8, 8'h3C);
        wr(4'd7, 8'hFF);
        wr(4'd8, 8'hFF);
        rd_chk("R2 en hi", 4'd7, 8'hFF);
        rd_chk("R2 en lo", 4'd8, 8'hFF);

        // R4 latch and request
        pulse(16'h0008);
        rd_chk("R4 pend lo", 4'd10, 8'h08);
        check("R4 irq_n", int'(irq_n), 0);

        // R5 disable clears pending; other request keeps irq
        pulse(16'h0400);
        wr(4'd8, 8'hF7);
        rd_chk("R5 pend lo", 4'd10, 0);
        rd_chk("R5 pend hi", 4'd9, 8'h04);
        check("R5 irq_n other", int'(irq_n), 0);
        wr(4'd9, 8'h00);
        check("R10 irq_n after clear", int'(irq_n), 1);
        wr(4'd8, 8'hFF);

        // R6 masking, R10 write 1 keeps
        wr(4'd13, 8'h80);
        pulse(16'h8000);
        rd_chk("R6 pend hi", 4'd9, 8'h80);
        check("R6 irq_n masked", int'(irq_n), 1);
        wr(4'd9, 8'hFF);
        rd_chk("R10 pend write 1", 4'd9, 8'h80);
        wr(4'd13, 8'h00);
        check("R6 irq_n unmasked", int'(irq_n), 0);
        do_ack(15);
        @(negedge clk);
        rd_chk("R7 pend cleared", 4'd9, 0);
        rd_chk("R12 isv hi", 4'd11, 0);
        check("R7 irq_n idle", int'(irq_n), 1);

        // R7 priority order
        pulse(16'h1022);
        do_ack(12);
        do_ack(5);
        do_ack(1);
        check("R7 irq_n drained", int'(irq_n), 1);
        rd_chk("R12 isv lo", 4'd12, 0);

        // R8 software end-of-interrupt nesting
        wr(4'd15, 8'h01);
        rd_chk("R1 ctrl", 4'd15, 1);
        pulse(16'h0010);
        do_ack(4);
        rd_chk("R8 isv lo", 4'd12, 8'h10);
        pulse(16'h0004);
        rd_chk("R8 pend lo", 4'd10, 8'h04);
        check("R8 lower blocked", int'(irq_n), 1);
        pulse(16'h0200);
        check("R8 higher nests", int'(irq_n), 0);
        do_ack(9);
        rd_chk("R8 isv hi", 4'd11, 8'h02);

        // R9 disable keeps in-service
        wr(4'd7, 8'hFD);
        rd_chk("R9 isv hi", 4'd11, 8'h02);
        wr(4'd11, 8'hFF);
        rd_chk("R10 isv write 1", 4'd11, 8'h02);
        wr(4'd11, 8'h00);
        rd_chk("R10 isv clear", 4'd11, 0);
        check("R8 still blocked", int'(irq_n), 1);
        wr(4'd12, 8'h00);
        check("R8 unblocked", int'(irq_n), 0);
        do_ack(2);
        rd_chk("R8 isv lo ch2", 4'd12, 8'h04);
        wr(4'd12, 8'h00);

        // R11 event beats clear
        pulse(16'h0001);
        wr_evt(4'd10, 8'h00, 16'h0040);
        rd_chk("R11 pend lo", 4'd10, 8'h40);

        repeat (3) @(negedge clk);
        check("R7 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule